// File: doc/BRIEF.md
# Near Return Stack Sequencer

This block carries out a procedure return that stays within the current code segment. A start strobe launches it. Sampled with the strobe are the operand size, the stack-address size, an optional 16-bit release count, the current stack pointer and stack bounds, the code limit, and the shadow-stack pointer and enable. It checks that the bytes to be popped lie inside the stack bounds. It then reads the return pointer from memory through a valid/ready read port, little-endian, at the operand width. For the 16-bit operand size the value is truncated to 16 bits and checked against the code limit.

When shadow stacks are enabled, the block reads a second copy of the return pointer from the shadow-stack pointer. The width of that read is 4 bytes for the 16-bit and 32-bit operand sizes and 8 bytes for the 64-bit size. The second copy must equal the first. On success the block commits three values in one step: the new instruction pointer, the stack pointer and, when shadow stacks are enabled, the shadow-stack pointer. The stack pointer is advanced by the pop width plus any release count, and the sum wraps within the stack-address width only. On any fault nothing is committed. A one-cycle done pulse reports either success or a fault code. There is no code segment selector output, because this kind of return never changes it.

Top module: `ret_near_seq`

## Requirements
- R1: After reset, done_o, fault_o, mem_req_o, ip_o, sp_o and ssp_o are all zero.
- R2: The size inputs use the encoding 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit. The pop reads 2, 4 or 8 bytes by operand size. The read address is the stack pointer masked to the stack-address width (low 16, low 32 or all 64 bits). The popped value is taken from the low bytes of the read data (byte 0 least significant) and is zero-extended into ip_o.
- R3: The stack-limit check rejects the return when the address is below stk_lo_i, or when address + pop width - 1 is above stk_hi_i. A rejected return gives done_o with fault_o = 1 in the cycle after the start, and no memory read is issued. A return that ends exactly on stk_hi_i is accepted.
- R4: For the 16-bit operand size only, a popped 16-bit value greater than cs_lim_i gives fault_o = 2. The 32-bit and 64-bit sizes do not apply this check.
- R5: With shstk_en_i = 1, a second read is made at ssp_i after the pop. It covers 4 bytes for the 16-bit and 32-bit sizes and 8 bytes for the 64-bit size. If the zero-extended value differs from the popped pointer, the return gives fault_o = 3. If it matches, ssp_o becomes ssp_i + 4 or ssp_i + 8.
- R6: On success, the low stack-address-width bits of sp_o equal the masked stack pointer + pop width + (imm_i when has_imm_i = 1), wrapped within that width. The bits above that width equal sp_i.
- R7: done_o is a single-cycle pulse. fault_o is 0 on success and is 0 whenever done_o is low. ip_o, sp_o and ssp_o change only on a successful return and keep their values across a fault.
- R8: A start strobe that arrives while a return is in progress is ignored. A start presented in the cycle where done_o is high is accepted.
- R9: While mem_req_o is high and mem_rdy_i is low, the request stays high and mem_addr_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one return |
| opsz_i | input | 2 | Operand size (0=16, 1=32, 2/3=64) |
| asz_i | input | 2 | Stack-address size (0=16, 1=32, 2/3=64) |
| has_imm_i | input | 1 | Release count present |
| imm_i | input | 16 | Bytes to release after the pop |
| sp_i | input | 64 | Current stack pointer |
| stk_lo_i | input | 64 | Lowest valid stack address |
| stk_hi_i | input | 64 | Highest valid stack address |
| cs_lim_i | input | 32 | Code segment limit |
| shstk_en_i | input | 1 | Shadow-stack cross-check enable |
| ssp_i | input | 64 | Current shadow-stack pointer |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 64 | Read byte address |
| mem_rdy_i | input | 1 | Read accepted, data valid this cycle |
| mem_rdata_i | input | 64 | Read data, little-endian |
| ip_o | output | 64 | Committed instruction pointer |
| sp_o | output | 64 | Committed stack pointer |
| ssp_o | output | 64 | Committed shadow-stack pointer |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 0 none, 1 stack limit, 2 code limit, 3 shadow mismatch |

## Verification
Two events can fall in the same cycle: the completion pulse of one return and the acceptance of the next start. The bench provokes this by raising start in the very cycle it sees done_o high. It then expects the second return to finish with results built on the values the first one committed. A second case is a stray start that arrives while a read is stalled by a slow ready. The bench judges it by counting exactly one done pulse over a long window. That return must also use only the address and results of the original request.

// File: rtl/ret_pkg.sv
package ret_pkg;

    typedef enum logic [1:0] {
        SZ16  = 2'd0,
        SZ32  = 2'd1,
        SZ64  = 2'd2,
        SZ64R = 2'd3
    } ret_size_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_STACK = 2'd1,
        FLT_CODE  = 2'd2,
        FLT_SHAD  = 2'd3
    } ret_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POP_RA = 2'd1,
        ST_POP_SH = 2'd2
    } ret_state_e;

    function automatic logic [3:0] pop_bytes(input ret_size_e sz);
        case (sz)
            SZ16:    return 4'd2;
            SZ32:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] shadow_bytes(input ret_size_e sz);
        case (sz)
            SZ16, SZ32: return 4'd4;
            default:    return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/ret_lim_chk.sv
module ret_lim_chk #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ea_i,
    input  logic [3:0]      nbytes_i,
    input  logic [XLEN-1:0] lo_i,
    input  logic [XLEN-1:0] hi_i,
    output logic            flt_o
);
    logic [XLEN:0] last_byte;

    always_comb begin
        last_byte = {1'b0, ea_i} + (XLEN+1)'(nbytes_i) - (XLEN+1)'(1);
        flt_o     = (ea_i < lo_i) || (last_byte > {1'b0, hi_i});
    end
endmodule

// File: rtl/ret_data_sel.sv
module ret_data_sel #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rdata_i,
    input  logic [3:0]      nbytes_i,
    output logic [XLEN-1:0] val_o
);
    localparam int NBYTE = XLEN / 8;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign val_o[8*b +: 8] = (int'(nbytes_i) > b) ? rdata_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/ret_sp_calc.sv
module ret_sp_calc #(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] sp_i,
    input  logic [1:0]      asz_i,
    input  logic [3:0]      pop_bytes_i,
    input  logic            has_imm_i,
    input  logic [IMMW-1:0] imm_i,
    output logic [XLEN-1:0] sp_o
);
    localparam int NSZ = 3;

    logic [XLEN-1:0] inc;
    logic [XLEN-1:0] cand [NSZ];

    assign inc = XLEN'(pop_bytes_i) + (has_imm_i ? XLEN'(imm_i) : '0);

    for (genvar g = 0; g < NSZ; g++) begin : g_lane
        localparam int W = 16 << g;
        if (W >= XLEN) begin : g_full
            assign cand[g] = sp_i + inc;
        end else begin : g_part
            assign cand[g] = {sp_i[XLEN-1:W], sp_i[W-1:0] + inc[W-1:0]};
        end
    end

    always_comb begin
        case (asz_i)
            2'd0:    sp_o = cand[0];
            2'd1:    sp_o = cand[1];
            default: sp_o = cand[2];
        endcase
    end
endmodule

// File: rtl/ret_near_seq.sv
module ret_near_seq
    import ret_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16,
    parameter int CSLW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      opsz_i,
    input  logic [1:0]      asz_i,
    input  logic            has_imm_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] stk_lo_i,
    input  logic [XLEN-1:0] stk_hi_i,
    input  logic [CSLW-1:0] cs_lim_i,
    input  logic            shstk_en_i,
    input  logic [XLEN-1:0] ssp_i,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    input  logic            mem_rdy_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic [XLEN-1:0] ip_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] ssp_o,
    output logic            done_o,
    output logic [1:0]      fault_o
);
    typedef struct packed {
        ret_state_e      st;
        ret_size_e       opsz;
        logic [1:0]      asz;
        logic            imm_en;
        logic [IMMW-1:0] imm;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] ea;
        logic [CSLW-1:0] cslim;
        logic            shen;
        logic [XLEN-1:0] ssp;
        logic [XLEN-1:0] ip_tmp;
        logic [XLEN-1:0] ip_arch;
        logic [XLEN-1:0] sp_arch;
        logic [XLEN-1:0] ssp_arch;
        logic            done;
        ret_fault_e      fault;
    } seq_t;

    seq_t st_d, st_q;

    function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] sp,
                                                 input logic [1:0] asz);
        case (asz)
            2'd0:    return XLEN'(sp[15:0]);
            2'd1:    return XLEN'(sp[31:0]);
            default: return sp;
        endcase
    endfunction

    logic [XLEN-1:0] ea_in;
    logic [3:0]      nb_in;
    logic            lim_flt;
    logic [XLEN-1:0] pop_val;
    logic [XLEN-1:0] shd_val;
    logic [XLEN-1:0] sp_next;
    logic [3:0]      nb_q;

    assign ea_in = eff_addr(sp_i, asz_i);
    assign nb_in = pop_bytes(ret_size_e'(opsz_i));
    assign nb_q  = pop_bytes(st_q.opsz);

    ret_lim_chk #(.XLEN(XLEN)) u_lim (
        .ea_i     (ea_in),
        .nbytes_i (nb_in),
        .lo_i     (stk_lo_i),
        .hi_i     (stk_hi_i),
        .flt_o    (lim_flt)
    );

    ret_data_sel #(.XLEN(XLEN)) u_pop_sel (
        .rdata_i  (mem_rdata_i),
        .nbytes_i (nb_q),
        .val_o    (pop_val)
    );

    ret_data_sel #(.XLEN(XLEN)) u_shd_sel (
        .rdata_i  (mem_rdata_i),
        .nbytes_i (shadow_bytes(st_q.opsz)),
        .val_o    (shd_val)
    );

    ret_sp_calc #(.XLEN(XLEN), .IMMW(IMMW)) u_spc (
        .sp_i        (st_q.ea | (st_q.sp & ~eff_addr({XLEN{1'b1}}, st_q.asz))),
        .asz_i       (st_q.asz),
        .pop_bytes_i (nb_q),
        .has_imm_i   (st_q.imm_en),
        .imm_i       (st_q.imm),
        .sp_o        (sp_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = FLT_NONE;
        case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.opsz   = ret_size_e'(opsz_i);
                    st_d.asz    = asz_i;
                    st_d.imm_en = has_imm_i;
                    st_d.imm    = imm_i;
                    st_d.sp     = sp_i;
                    st_d.ea     = ea_in;
                    st_d.cslim  = cs_lim_i;
                    st_d.shen   = shstk_en_i;
                    st_d.ssp    = ssp_i;
                    if (lim_flt) begin
                        st_d.done  = 1'b1;
                        st_d.fault = FLT_STACK;
                    end else begin
                        st_d.st = ST_POP_RA;
                    end
                end
            end
            ST_POP_RA: begin
                if (mem_rdy_i) begin
                    st_d.ip_tmp = pop_val;
                    if (st_q.opsz == SZ16 && pop_val > XLEN'(st_q.cslim)) begin
                        st_d.st    = ST_IDLE;
                        st_d.done  = 1'b1;
                        st_d.fault = FLT_CODE;
                    end else if (st_q.shen) begin
                        st_d.st = ST_POP_SH;
                    end else begin
                        st_d.st      = ST_IDLE;
                        st_d.done    = 1'b1;
                        st_d.ip_arch = pop_val;
                        st_d.sp_arch = sp_next;
                    end
                end
            end
            ST_POP_SH: begin
                if (mem_rdy_i) begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                    if (shd_val != st_q.ip_tmp) begin
                        st_d.fault = FLT_SHAD;
                    end else begin
                        st_d.ip_arch  = st_q.ip_tmp;
                        st_d.sp_arch  = sp_next;
                        st_d.ssp_arch = st_q.ssp + XLEN'(shadow_bytes(st_q.opsz));
                    end
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req_o  = (st_q.st != ST_IDLE);
    assign mem_addr_o = (st_q.st == ST_POP_RA) ? st_q.ea : st_q.ssp;
    assign ip_o       = st_q.ip_arch;
    assign sp_o       = st_q.sp_arch;
    assign ssp_o      = st_q.ssp_arch;
    assign done_o     = st_q.done;
    assign fault_o    = st_q.fault;
endmodule

// File: rtl/ret_near_seq_chk.sv
module ret_near_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic            mem_rdy_i,
    input logic [XLEN-1:0] ip_o,
    input logic [XLEN-1:0] sp_o,
    input logic [XLEN-1:0] ssp_o,
    input logic            done_o,
    input logic [1:0]      fault_o
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o))); // R9

    AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != 2'd0) |-> ($stable(ip_o) && $stable(sp_o) && $stable(ssp_o))); // R7

    AST_FAULT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (fault_o == 2'd0)); // R7

    AST_LIMIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 2'd1) |-> !$past(mem_req_o)); // R3

    AST_SHADOW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 2'd3) |-> $past(mem_req_o && mem_rdy_i)); // R5

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R8
endmodule

bind ret_near_seq ret_near_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_rdy_i  (mem_rdy_i),
    .ip_o       (ip_o),
    .sp_o       (sp_o),
    .ssp_o      (ssp_o),
    .done_o     (done_o),
    .fault_o    (fault_o)
);

// File: tb/ret_near_seq_tb.sv
`timescale 1ns/1ps
module ret_near_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [1:0]  opsz_i, asz_i;
    logic        has_imm_i;
    logic [15:0] imm_i;
    logic [63:0] sp_i, stk_lo_i, stk_hi_i, ssp_i;
    logic [31:0] cs_lim_i;
    logic        shstk_en_i;
    logic        mem_req_o, mem_rdy_i;
    logic [63:0] mem_addr_o, mem_rdata_i;
    logic [63:0] ip_o, sp_o, ssp_o;
    logic        done_o;
    logic [1:0]  fault_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // scenario configuration
    logic [1:0]  c_opsz, c_asz;
    logic        c_imm_en, c_shen;
    logic [15:0] c_imm;
    logic [63:0] c_sp, c_lo, c_hi, c_ssp, c_stk, c_shd;
    logic [31:0] c_csl;
    int          c_lat;

    // expected architectural state
    logic [63:0] e_ip = '0, e_sp = '0, e_ssp = '0;
    logic [1:0]  x_fault;
    int          x_reads;
    logic [63:0] x_addr0;

    always #10 clk = ~clk;

    ret_near_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opsz_i(opsz_i), .asz_i(asz_i),
        .has_imm_i(has_imm_i), .imm_i(imm_i), .sp_i(sp_i), .stk_lo_i(stk_lo_i),
        .stk_hi_i(stk_hi_i), .cs_lim_i(cs_lim_i), .shstk_en_i(shstk_en_i), .ssp_i(ssp_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdy_i(mem_rdy_i),
        .mem_rdata_i(mem_rdata_i), .ip_o(ip_o), .sp_o(sp_o), .ssp_o(ssp_o),
        .done_o(done_o), .fault_o(fault_o)
    );

    // memory responder
    int wcnt = 0;
    int rd_cnt = 0;
    logic [63:0] rd_hist [256];
    assign mem_rdy_i   = mem_req_o && (wcnt >= c_lat);
    assign mem_rdata_i = (c_shen && mem_addr_o == c_ssp) ? c_shd : c_stk;
    always @(posedge clk) begin
        wcnt <= (mem_req_o && !mem_rdy_i) ? wcnt + 1 : 0;
        if (mem_req_o && mem_rdy_i) begin
            rd_hist[rd_cnt % 256] <= mem_addr_o;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] bmask(input int nb);
        return (nb >= 8) ? {64{1'b1}} : ((64'd1 << (8 * nb)) - 64'd1);
    endfunction

    task automatic model();
        int w, sw;
        logic [63:0] ea, val, sv, inc, nsp;
        logic [64:0] last;
        w  = (c_opsz == 2'd0) ? 2 : (c_opsz == 2'd1) ? 4 : 8;
        sw = (c_opsz >= 2'd2) ? 8 : 4;
        ea = (c_asz == 2'd0) ? (c_sp & 64'hFFFF) :
             (c_asz == 2'd1) ? (c_sp & 64'hFFFF_FFFF) : c_sp;
        last = {1'b0, ea} + 65'(w) - 65'd1;
        x_addr0 = ea;
        if (ea < c_lo || last > {1'b0, c_hi}) begin
            x_fault = 2'd1; x_reads = 0;
        end else begin
            val = c_stk & bmask(w);
            x_reads = 1;
            x_fault = 2'd0;
            if (c_opsz == 2'd0 && val > {32'd0, c_csl}) begin
                x_fault = 2'd2;
            end else if (c_shen) begin
                x_reads = 2;
                sv = c_shd & bmask(sw);
                if (sv != val) x_fault = 2'd3;
            end
            if (x_fault == 2'd0) begin
                inc = 64'(w) + (c_imm_en ? {48'd0, c_imm} : 64'd0);
                case (c_asz)
                    2'd0:    nsp = {c_sp[63:16], c_sp[15:0] + inc[15:0]};
                    2'd1:    nsp = {c_sp[63:32], c_sp[31:0] + inc[31:0]};
                    default: nsp = c_sp + inc;
                endcase
                e_ip = val;
                e_sp = nsp;
                if (c_shen) e_ssp = c_ssp + 64'(sw);
            end
        end
    endtask

    task automatic drive_cfg();
        opsz_i = c_opsz; asz_i = c_asz; has_imm_i = c_imm_en; imm_i = c_imm;
        sp_i = c_sp; stk_lo_i = c_lo; stk_hi_i = c_hi; cs_lim_i = c_csl;
        shstk_en_i = c_shen; ssp_i = c_ssp;
    endtask

    task automatic run(input string tag, input bit poke, input bit chained);
        int base, dones;
        bit seen;
        logic [63:0] a_ip, a_sp, a_ssp;
        logic [1:0]  a_fault;
        model();
        base = rd_cnt;
        if (!chained) @(negedge clk);
        drive_cfg();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dones = 0; seen = 0;
        a_ip = '0; a_sp = '0; a_ssp = '0; a_fault = '0;
        for (int i = 0; i < 60; i++) begin
            if (poke && i == 1) begin start_i = 1'b1; sp_i = ~c_sp; opsz_i = 2'd0; end
            if (poke && i == 2) begin start_i = 1'b0; sp_i = c_sp; opsz_i = c_opsz; end
            if (done_o) begin
                dones++;
                if (!seen) begin
                    seen = 1; a_ip = ip_o; a_sp = sp_o; a_ssp = ssp_o; a_fault = fault_o;
                end
            end
            if (seen && !poke) break;
            @(negedge clk);
        end
        chk(tag, "done pulses", 64'(dones), 64'd1);
        chk(tag, "fault", {62'd0, a_fault}, {62'd0, x_fault});
        chk(tag, "ip", a_ip, e_ip);
        chk(tag, "sp", a_sp, e_sp);
        chk(tag, "ssp", a_ssp, e_ssp);
        chk(tag, "reads", 64'(rd_cnt - base), 64'(x_reads));
        if (x_reads > 0) chk(tag, "pop address", rd_hist[base % 256], x_addr0);
        if (x_reads > 1) chk(tag, "shadow address", rd_hist[(base + 1) % 256], c_ssp);
    endtask

    task automatic set_cfg(input logic [1:0] op, input logic [1:0] az, input logic ie,
                           input logic [15:0] im, input logic [63:0] sp,
                           input logic [63:0] lo, input logic [63:0] hi,
                           input logic [31:0] csl, input logic sh, input logic [63:0] ssp,
                           input logic [63:0] stk, input logic [63:0] shd, input int lat);
        c_opsz = op; c_asz = az; c_imm_en = ie; c_imm = im; c_sp = sp; c_lo = lo;
        c_hi = hi; c_csl = csl; c_shen = sh; c_ssp = ssp; c_stk = stk; c_shd = shd;
        c_lat = lat;
    endtask

    task automatic t_reset();
        chk("R1", "done", {63'd0, done_o}, 64'd0);
        chk("R1", "fault", {62'd0, fault_o}, 64'd0);
        chk("R1", "req", {63'd0, mem_req_o}, 64'd0);
        chk("R1", "ip", ip_o, 64'd0);
        chk("R1", "sp", sp_o, 64'd0);
        chk("R1", "ssp", ssp_o, 64'd0);
    endtask

    task automatic t_pop64();
        set_cfg(2'd2, 2'd2, 1, 16'h0020, 64'h0000_7000_0000_1000, 64'd0, '1, 32'h100,
                0, 64'h0, 64'h1122_3344_5566_7788, 64'h0, 0);
        run("R2 R6 pop64", 0, 0);
    endtask

    task automatic t_pop32_wrap();
        set_cfg(2'd1, 2'd1, 1, 16'h0010, 64'hABCD_0000_FFFF_FFFC, 64'd0, '1, 32'h100,
                0, 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 2);
        run("R2 R4 R6 R9 pop32 wrap", 0, 0);
    endtask

    task automatic t_pop16_wrap();
        set_cfg(2'd0, 2'd0, 0, 16'h0000, 64'h1234_5678_9ABC_FFFE, 64'd0, 64'hFFFF,
                32'h8000, 0, 64'h0, 64'h5555_5555_5555_7FFF, 64'h0, 1);
        run("R2 R3 R4 R6 pop16 at limits", 0, 0);
    endtask

    task automatic t_code_fault();
        set_cfg(2'd0, 2'd0, 1, 16'h0004, 64'h0000_0000_0000_0200, 64'd0, 64'hFFFF,
                32'h8000, 0, 64'h0, 64'h0000_0000_0000_8001, 64'h0, 0);
        run("R4 R7 code limit", 0, 0);
    endtask

    task automatic t_limits();
        set_cfg(2'd1, 2'd2, 0, 16'h0, 64'h0FFE, 64'h1000, 64'h1FFF, 32'h100,
                0, 64'h0, 64'h1, 64'h0, 0);
        run("R3 below low bound", 0, 0);
        set_cfg(2'd2, 2'd2, 0, 16'h0, 64'h1FF9, 64'h1000, 64'h1FFF, 32'h100,
                0, 64'h0, 64'h1, 64'h0, 0);
        run("R3 past high bound", 0, 0);
        set_cfg(2'd2, 2'd2, 0, 16'h0, 64'h1FF8, 64'h1000, 64'h1FFF, 32'h100,
                0, 64'h0, 64'h0000_0000_4444_0000, 64'h0, 0);
        run("R3 exact fit", 0, 0);
    endtask

    task automatic t_shadow();
        set_cfg(2'd1, 2'd1, 0, 16'h0, 64'h3000, 64'd0, '1, 32'h100,
                1, 64'h8000, 64'h0000_0000_1357_9BDF, 64'hFFFF_FFFF_1357_9BDF, 1);
        run("R5 shadow 4-byte match", 0, 0);
        set_cfg(2'd2, 2'd2, 1, 16'h0008, 64'h3100, 64'd0, '1, 32'h100,
                1, 64'h9000, 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708, 0);
        run("R5 R6 shadow 8-byte match", 0, 0);
        set_cfg(2'd2, 2'd2, 0, 16'h0, 64'h3200, 64'd0, '1, 32'h100,
                1, 64'hA000, 64'h0102_0304_0506_0708, 64'h8102_0304_0506_0708, 0);
        run("R5 R7 shadow mismatch", 0, 0);
        set_cfg(2'd0, 2'd0, 0, 16'h0, 64'h3300, 64'd0, '1, 32'hFFFF,
                1, 64'hB000, 64'h0000_0000_AAAA_1234, 64'h0000_0000_0000_1234, 0);
        run("R5 shadow with 16-bit pop", 0, 0);
    endtask

    task automatic t_busy();
        set_cfg(2'd2, 2'd2, 0, 16'h0, 64'h5000, 64'd0, '1, 32'h100,
                1, 64'hC000, 64'h0BAD_F00D_0000_0001, 64'h0BAD_F00D_0000_0001, 4);
        run("R8 R9 start while busy", 1, 0);
    endtask

    task automatic t_chain();
        set_cfg(2'd1, 2'd1, 0, 16'h0, 64'h6000, 64'd0, '1, 32'h100,
                0, 64'h0, 64'h0000_0000_0000_6666, 64'h0, 0);
        run("R7 R8 first of pair", 0, 0);
        set_cfg(2'd2, 2'd2, 1, 16'h0100, 64'h7000, 64'd0, '1, 32'h100,
                0, 64'h0, 64'h0000_0000_0000_7777, 64'h0, 0);
        run("R8 start in done cycle", 0, 1);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0;
        set_cfg(2'd0, 2'd0, 0, 16'h0, 64'h0, 64'h0, 64'h0, 32'h0, 0, 64'h1, 64'h0, 64'h0, 0);
        drive_cfg();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pop64();
        t_pop32_wrap();
        t_pop16_wrap();
        t_code_fault();
        t_limits();
        t_shadow();
        t_busy();
        t_chain();
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule